// File: doc/BRIEF.md
# Word-to-Beat Packing Buffer

This block gathers 32-bit words that arrive in groups of zero to four per cycle and repacks them into dense 128-bit beats. Each input cycle presents a 128-bit bus in which the valid words sit at the lowest word positions, together with a count of how many are valid. The block appends those words directly after the words it already holds, keeping arrival order. As soon as four or more words are held, it presents one full beat and discards those four words from its store.

The store is seven words deep. That is enough for three leftover words plus a full group of four new ones. A single merge step does the work each cycle: it shifts the held contents down by zero or four words and shifts the masked new words up by the leftover count. Because the two parts never occupy the same bit positions, it combines them with a bitwise OR. A flush request pushes out a partial final beat of one to three words, with the unused upper words driven to zero, and then empties the store.

Top module: `word_packer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_valid` is 0 and `out_cnt` is 0. Reset is synchronous and active high, and it clears the held-word count and the store.
- R2: Words leave in arrival order. Word 0 (bits 31:0) of a beat is the oldest. Within one input cycle, input word k (bits 32k+31:32k) is older than input word k+1.
- R3: Input words at positions at or above `in_cnt` have no effect on any output beat. `in_cnt` must be 4 or less whenever `in_valid` is 1.
- R4: In every cycle in which four or more words are held, `out_valid` is 1 and `out_cnt` is 4. `out_data` carries the four oldest held words, and those four words are removed at the next clock edge.
- R5: A cycle with `in_valid` at 0 adds no words, whatever `in_cnt` and `in_data` carry.
- R6: In any beat, the words at positions at or above `out_cnt` are zero.
- R7: When `flush` is 1 and one to three words are held, `out_valid` is 1 in that same cycle and `out_cnt` equals the held count. `out_data` carries those words, and the held count becomes zero at the next edge, apart from any words arriving in that cycle.
- R8: `flush` has no effect when no words are held, where `out_valid` stays 0. It also has no effect when four or more are held, where only the normal full beat is emitted and the leftover words remain held.
- R9: Words that arrive in the same cycle as an emitted beat, whether full or partial, are kept and become the oldest words after the remaining held words.
- R10: A word presented at a clock edge can appear on `out_data` in the cycle right after that edge. A steady input of four words per cycle yields one full beat every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input group present this cycle |
| in_cnt | input | 3 | Number of valid words in `in_data` (0 to 4) |
| in_data | input | 128 | Input words, valid ones packed from word 0 upward |
| flush | input | 1 | Request to emit a partial final beat |
| out_valid | output | 1 | Beat present on `out_data` this cycle |
| out_cnt | output | 3 | Number of valid words in the beat (4 for full, 1 to 3 for a flush) |
| out_data | output | 128 | Output beat, oldest word in word 0 |

## Verification
The assertions assume that the input never claims more than four valid words while `in_valid` is high. They also assume there is no backpressure, so every beat is taken in the cycle it is shown. The stimulus only ever issues counts from zero to four. It fills the positions above the count with a fixed junk pattern, so that any leak into the OR merge shows up in the data. The scoreboard model walks the same word-count arithmetic on a plain queue of words. It expects a beat, or its absence, in every cycle. This covers flushes issued with zero, partial and full stores, and flushes issued alongside new input.

// File: rtl/wpk_pkg.sv
package wpk_pkg;

    // What the store does with its held words this cycle
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,   // nothing emitted, held words stay in place
        ACT_FULL = 2'd1,   // four oldest words emitted and dropped
        ACT_TAIL = 2'd2    // partial beat emitted on flush, store emptied
    } pack_act_e;

    // Bit offset of word lane idx for words of width w
    function automatic int lane_lo(input int idx, input int w);
        return idx * w;
    endfunction

endpackage

// File: rtl/wpk_ctrl.sv
module wpk_ctrl
    import wpk_pkg::*;
#(
    parameter int BEAT_WORDS = 4,
    parameter int IN_W       = 3,
    parameter int CNT_W      = 3
) (
    input  logic [CNT_W-1:0] held_q,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_cnt,
    input  logic             flush,
    output pack_act_e        act,
    output logic [CNT_W-1:0] base,
    output logic [CNT_W-1:0] held_d,
    output logic [CNT_W-1:0] emit_cnt,
    output logic [IN_W-1:0]  take
);
    localparam logic [CNT_W-1:0] BEAT_C  = CNT_W'(BEAT_WORDS);
    localparam logic [IN_W-1:0]  BEAT_IN = IN_W'(BEAT_WORDS);

    always_comb begin
        // accepted word count, clamped to a beat
        if (!in_valid)            take = '0;
        else if (in_cnt > BEAT_IN) take = BEAT_IN;
        else                      take = in_cnt;

        if (held_q >= BEAT_C)            act = ACT_FULL;
        else if (flush && held_q != '0)  act = ACT_TAIL;
        else                             act = ACT_HOLD;

        case (act)
            ACT_FULL: begin base = held_q - BEAT_C; emit_cnt = BEAT_C; end
            ACT_TAIL: begin base = '0;              emit_cnt = held_q; end
            default:  begin base = held_q;          emit_cnt = '0;     end
        endcase

        held_d = base + CNT_W'(take);
    end
endmodule

// File: rtl/wpk_mask.sv
module wpk_mask
    import wpk_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int BEAT_WORDS = 4,
    parameter int IN_W       = 3
) (
    input  logic [WORD_W*BEAT_WORDS-1:0] in_data,
    input  logic [IN_W-1:0]              take,
    output logic [WORD_W*BEAT_WORDS-1:0] masked
);
    for (genvar g = 0; g < BEAT_WORDS; g++) begin : g_lane
        assign masked[lane_lo(g, WORD_W) +: WORD_W] =
            (g < int'(take)) ? in_data[lane_lo(g, WORD_W) +: WORD_W] : '0;
    end
endmodule

// File: rtl/wpk_align.sv
module wpk_align
    import wpk_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int BEAT_WORDS = 4,
    parameter int HOLD_WORDS = 7,
    parameter int CNT_W      = 3
) (
    input  logic [WORD_W*HOLD_WORDS-1:0] held_buf,
    input  pack_act_e                    act,
    input  logic [CNT_W-1:0]             base,
    input  logic [WORD_W*BEAT_WORDS-1:0] masked,
    output logic [WORD_W*HOLD_WORDS-1:0] next_buf
);
    localparam int BUF_W  = WORD_W * HOLD_WORDS;
    localparam int BEAT_W = WORD_W * BEAT_WORDS;

    logic [BUF_W-1:0] kept;
    logic [BUF_W-1:0] incoming;

    always_comb begin
        case (act)
            ACT_FULL: kept = held_buf >> BEAT_W;
            ACT_TAIL: kept = '0;
            default:  kept = held_buf;
        endcase
        // new words land right above the leftover words; no overlap with kept
        incoming = {{(BUF_W-BEAT_W){1'b0}}, masked} << (int'(base) * WORD_W);
        next_buf = kept | incoming;
    end
endmodule

// File: rtl/word_packer.sv
module word_packer
    import wpk_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int BEAT_WORDS = 4,
    parameter int IN_W       = $clog2(BEAT_WORDS + 1),
    parameter int CNT_W      = $clog2(2 * BEAT_WORDS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [IN_W-1:0]              in_cnt,
    input  logic [WORD_W*BEAT_WORDS-1:0] in_data,
    input  logic                         flush,
    output logic                         out_valid,
    output logic [CNT_W-1:0]             out_cnt,
    output logic [WORD_W*BEAT_WORDS-1:0] out_data
);
    localparam int HOLD_WORDS = 2 * BEAT_WORDS - 1;
    localparam int BUF_W      = WORD_W * HOLD_WORDS;
    localparam int BEAT_W     = WORD_W * BEAT_WORDS;

    logic [BUF_W-1:0]  buf_q, buf_d;
    logic [CNT_W-1:0]  held_q, held_d, base, emit_cnt;
    logic [IN_W-1:0]   take;
    logic [BEAT_W-1:0] masked;
    pack_act_e         act;

    wpk_ctrl #(.BEAT_WORDS(BEAT_WORDS), .IN_W(IN_W), .CNT_W(CNT_W)) u_ctrl (
        .held_q(held_q), .in_valid(in_valid), .in_cnt(in_cnt), .flush(flush),
        .act(act), .base(base), .held_d(held_d), .emit_cnt(emit_cnt), .take(take)
    );

    wpk_mask #(.WORD_W(WORD_W), .BEAT_WORDS(BEAT_WORDS), .IN_W(IN_W)) u_mask (
        .in_data(in_data), .take(take), .masked(masked)
    );

    wpk_align #(.WORD_W(WORD_W), .BEAT_WORDS(BEAT_WORDS),
                .HOLD_WORDS(HOLD_WORDS), .CNT_W(CNT_W)) u_align (
        .held_buf(buf_q), .act(act), .base(base), .masked(masked), .next_buf(buf_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            held_q <= '0;
        end else begin
            buf_q  <= buf_d;
            held_q <= held_d;
        end
    end

    assign out_valid = (act != ACT_HOLD);
    assign out_cnt   = emit_cnt;
    assign out_data  = buf_q[BEAT_W-1:0];

    // R3: input count never exceeds a beat while valid
    p_in_cnt_legal_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (int'(in_cnt) <= BEAT_WORDS));

    // R6: store positions above the held count are always zero
    p_upper_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (buf_q >> (int'(held_q) * WORD_W)) == '0);

    // R7: a partial beat with no new words leaves an empty store
    p_tail_empties_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && int'(out_cnt) < BEAT_WORDS && !in_valid) |=> (held_q == '0));

    // R9: accepted words are never dropped
    p_keep_words_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cnt != '0) |=> (held_q != '0));

    // R4: a full beat with no input drops exactly four words
    p_full_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (int'(out_cnt) == BEAT_WORDS && !in_valid) |=>
            (int'(held_q) == int'($past(held_q)) - BEAT_WORDS));
endmodule

// File: tb/word_packer_bench.sv
module word_packer_bench;
    localparam int PERIOD = 10;

    typedef struct {
        logic         v;
        logic [2:0]   c;
        logic [127:0] d;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [2:0]   in_cnt = '0;
    logic [127:0] in_data = '0;
    logic         flush = 1'b0;
    logic         out_valid;
    logic [2:0]   out_cnt;
    logic [127:0] out_data;

    int    total = 0;
    int    bad = 0;
    bit    mon_en = 1'b0;
    string cur_tag = "R1";
    logic [31:0] seq = 32'hC0DE_0000;

    exp_t        sb[$];
    logic [31:0] model[$];

    word_packer u_word_packer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_cnt(in_cnt),
        .in_data(in_data), .flush(flush), .out_valid(out_valid),
        .out_cnt(out_cnt), .out_data(out_data)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: one call per clock cycle; model predicts this cycle's beat
    task automatic drive(input bit v, input int n, input bit fl);
        exp_t e;
        logic [127:0] d;
        @(posedge clk);
        #1;
        d = '1 ^ 128'h0;
        for (int k = 0; k < 4; k++) d[k*32 +: 32] = 32'hDEAD_BEEF;
        for (int k = 0; k < n; k++) begin
            d[k*32 +: 32] = seq;
            seq = seq + 1;
        end
        in_valid = v;
        in_cnt   = 3'(n);
        in_data  = d;
        flush    = fl;
        e.v = 1'b0; e.c = '0; e.d = '0; e.tag = cur_tag;
        if (model.size() >= 4) begin
            e.v = 1'b1; e.c = 3'd4;
            for (int k = 0; k < 4; k++) e.d[k*32 +: 32] = model.pop_front();
        end else if (fl && model.size() > 0) begin
            e.v = 1'b1; e.c = 3'(model.size());
            for (int k = 0; k < 3; k++)
                if (model.size() > 0) e.d[k*32 +: 32] = model.pop_front();
        end
        if (v) for (int k = 0; k < n; k++) model.push_back(d[k*32 +: 32]);
        sb.push_back(e);
        mon_en = 1'b1;
    endtask

    // monitor: pops one expectation per cycle, away from the active edge
    always @(negedge clk) begin
        if (mon_en) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10", "scoreboard empty", 128'(out_valid), 128'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_valid == e.v, e.tag, "out_valid", 128'(out_valid), 128'(e.v));
                if (e.v && out_valid) begin
                    check(out_cnt == e.c, e.tag, "out_cnt", 128'(out_cnt), 128'(e.c));
                    check(out_data == e.d, e.tag, "out_data (R2 order, R6 zero fill)",
                          out_data, e.d);
                end
            end
        end
    end

    initial begin
        #(PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state, including a flush request while in reset
        flush = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", 128'(out_valid), 128'h0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        flush = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_cnt == 3'd0, "R1", "state after reset",
              128'({out_valid, out_cnt}), 128'h0);

        // R10: single full group emerges in the next cycle
        cur_tag = "R10"; drive(1, 4, 0); drive(0, 0, 0);
        // R10: steady four-word stream, one beat per cycle
        for (int i = 0; i < 5; i++) drive(1, 4, 0);
        drive(0, 0, 0);

        // R2 and R3: odd group sizes with junk above the count
        cur_tag = "R2";
        drive(1, 1, 0); drive(1, 3, 0); drive(1, 2, 0); drive(1, 3, 0);
        cur_tag = "R3";
        drive(1, 3, 0); drive(1, 1, 0); drive(1, 2, 0); drive(1, 0, 0);
        drive(1, 4, 0); drive(1, 3, 0);

        // R5: invalid cycles with nonzero count add nothing
        cur_tag = "R5";
        drive(0, 4, 0); drive(0, 2, 0); drive(0, 0, 0); drive(0, 0, 0);

        // R7: flush out the remaining words, then flush with 1 and 2 held
        cur_tag = "R7";
        drive(0, 0, 1); drive(0, 0, 0);
        drive(1, 1, 0); drive(0, 0, 1);
        drive(1, 2, 0); drive(0, 0, 1); drive(0, 0, 0);

        // R8: flush with nothing held; flush with 5 held
        cur_tag = "R8";
        drive(0, 0, 1); drive(0, 0, 0);
        drive(1, 2, 0); drive(1, 3, 0); drive(0, 0, 1); drive(0, 0, 0);
        drive(0, 0, 1); drive(0, 0, 0);

        // R9: input arriving together with partial and full beats
        cur_tag = "R9";
        drive(1, 3, 0); drive(1, 4, 1); drive(1, 2, 0); drive(1, 1, 1);
        drive(1, 4, 1); drive(0, 0, 1); drive(0, 0, 1); drive(0, 0, 0);

        // R4: fill to seven, then drain
        cur_tag = "R4";
        drive(1, 3, 0); drive(1, 4, 0); drive(1, 4, 0); drive(0, 0, 0);
        drive(0, 0, 0); drive(0, 0, 1); drive(0, 0, 0);

        @(negedge clk);
        #1;
        mon_en = 1'b0;
        check(model.size() == 0 && sb.size() == 0, "R4", "words left over",
              128'(model.size()), 128'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule